// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block watches the live calendar time of a real-time clock and raises an alarm when the time reaches a programmed setting. The time arrives in BCD form, one bus for each of seconds, minutes, hours, day of month and weekday. A strobe marks each seconds update. Software programs five alarm setting registers and one control register through a byte-wide register port.

Each alarm setting register has an exclusion bit. A field whose exclusion bit is set drops out of the comparison. The alarm fires when every field that still takes part equals the live time on the bits that field compares. The comparison is made only when the seconds strobe is high, so one matching second sets the alarm flag once. The flag stays set until software clears it. An active-low interrupt request follows the flag, gated by an interrupt enable bit.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the five alarm setting registers read 0x80, the control register reads 0x00, `alarm_flag` is 0 and `irq_n` is 1.
- R2: The register map is as follows. Address 0x0A holds the seconds setting, 0x0B minutes, 0x0C hours, 0x0D day of month and 0x0E weekday, and each stores and returns all 8 bits. Address 0x01 is the control register: bit 1 is the interrupt enable and bit 4 is the alarm flag. Its other bits read 0. Any other address reads 0x00, and a write to it changes no register.
- R3: Bit 7 of a setting register excludes that field when set. A match requires every field whose bit 7 is clear to equal the live time on its compared bits.
- R4: The compared widths are 7 bits for seconds and minutes, 6 bits for hours and day of month, and 3 bits for weekday. Setting bits above the compared width, other than bit 7, have no effect.
- R5: When all five fields are excluded, the alarm flag is never set.
- R6: The match is evaluated only in a cycle where `sec_tick` is 1. A match in that cycle sets `alarm_flag` from the next cycle on. Without `sec_tick` the flag is not set, whatever the time inputs are.
- R7: Writing the control register with bit 4 = 0 clears the flag. Writing bit 4 = 1 leaves the flag unchanged. If a clearing write and a match on `sec_tick` fall in the same cycle, the flag ends up set.
- R8: Once set, the flag stays set through further ticks, matching or not, until a clearing write.
- R9: `irq_n` is 0 exactly when the flag is set and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe for a seconds update |
| cur_sec | input | 7 | Live seconds, BCD |
| cur_min | input | 7 | Live minutes, BCD |
| cur_hour | input | 6 | Live hours, BCD |
| cur_day | input | 6 | Live day of month, BCD |
| cur_wday | input | 3 | Live weekday, 0 to 6 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| alarm_flag | output | 1 | Alarm flag |
| irq_n | output | 1 | Alarm interrupt request, active low |

## Verification
The hardest case to reach is the one where only some fields are enabled and the fields that are ignored disagree with the time. The bench gets there by sweeping all 32 enable masks against all 32 patterns of which fields are deliberately off by one from a fixed time. Setting bits that lie above each field's width but below bit 7 need their own settings, which the bench programs. The race between a clearing write and a matching tick only shows up if both land in the same clock cycle, so the bench drives them together in a single cycle.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared constants for the calendar alarm comparator.
// Assumes 5-bit register addresses and byte-wide registers.
package rtc_alarm_pkg;
    localparam int NFIELD = 5;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADR_CTRL     = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_ALM_BASE = 5'h0A;

    localparam int BIT_AIE = 1;
    localparam int BIT_AF  = 4;
    localparam int BIT_OFF = 7;

    // Compare mask per field: sec, min, hour, day, weekday.
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        case (idx)
            0, 1:    field_mask = 8'h7F;
            2, 3:    field_mask = 8'h3F;
            default: field_mask = 8'h07;
        endcase
    endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
// Register file for the alarm settings and the control register.
// Assumes the write strobe lasts one cycle per write. The read port is combinational.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NFIELD,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic                   flag_in,
    output logic [DW-1:0]          rdata,
    output logic [NF-1:0][DW-1:0]  setting,
    output logic                   aie,
    output logic                   clr_req
);
    localparam logic [DW-1:0] SET_RST = DW'(1) << BIT_OFF;

    logic ctrl_sel;
    assign ctrl_sel = wr_en && (addr == ADR_CTRL);
    assign clr_req  = ctrl_sel && !wdata[BIT_AF];

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_set
            // Purpose: hold one alarm setting byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    setting[gi] <= SET_RST;
                else if (wr_en && addr == ADR_ALM_BASE + AW'(gi))
                    setting[gi] <= wdata;
            end
        end
    endgenerate

    // Purpose: hold the interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aie <= 1'b0;
        else if (ctrl_sel)
            aie <= wdata[BIT_AIE];
    end

    // Purpose: return the addressed register.
    always_comb begin
        rdata = '0;
        if (addr == ADR_CTRL) begin
            rdata[BIT_AIE] = aie;
            rdata[BIT_AF]  = flag_in;
        end
        for (int i = 0; i < NF; i++)
            if (addr == ADR_ALM_BASE + AW'(i))
                rdata = setting[i];
    end

    // Settings hold unless their own address is written (R2).
    a_r2_setting_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr >= ADR_ALM_BASE && addr < ADR_ALM_BASE + AW'(NF)) |=> $stable(setting));
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Field comparator: masks each field to its compared width and skips fields excluded by bit 7.
// Assumes the live time is already zero-extended to the byte width.
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NFIELD,
    parameter int DW = DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NF-1:0][DW-1:0]  setting,
    input  logic [NF-1:0][DW-1:0]  now_time,
    output logic                   match
);
    logic [NF-1:0] use_f;
    logic [NF-1:0] eq_f;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_fld
            localparam logic [DW-1:0] MSK = field_mask(gi);
            assign use_f[gi] = !setting[gi][BIT_OFF];
            assign eq_f[gi]  = (setting[gi] & MSK) == (now_time[gi] & MSK);
        end
    endgenerate

    // Purpose: match when at least one field is used and all used fields agree.
    always_comb match = (|use_f) && (&(eq_f | ~use_f));

    // With every field excluded there is no match (R5).
    a_r5_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (use_f == '0) |-> !match);
endmodule

// File: rtl/rtc_alarm_flag.sv
// Alarm flag and interrupt: sets on a match at a seconds tick and clears on a software write.
// Assumes a set and a clear in the same cycle resolve to set.
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic clr_req,
    input  logic aie,
    output logic flag,
    output logic irq_n
);
    logic hit;
    assign hit = tick && match;

    // Purpose: sticky flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    assign irq_n = !(flag && aie);

    a_r6_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    a_r6_no_set_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !hit) |=> !flag);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !hit) |=> !flag);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/rtc_alarm_match.sv
// Top level of the calendar alarm comparator: register port, field compare and sticky flag.
// Assumes BCD inputs that are stable whenever sec_tick is high.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NFIELD,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [6:0]    cur_sec,
    input  logic [6:0]    cur_min,
    input  logic [5:0]    cur_hour,
    input  logic [5:0]    cur_day,
    input  logic [2:0]    cur_wday,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          alarm_flag,
    output logic          irq_n
);
    logic [NF-1:0][DW-1:0] setting;
    logic [NF-1:0][DW-1:0] now_time;
    logic aie, clr_req, match;

    // Purpose: zero-extend the live time into byte lanes.
    always_comb begin
        now_time    = '0;
        now_time[0] = DW'(cur_sec);
        now_time[1] = DW'(cur_min);
        now_time[2] = DW'(cur_hour);
        now_time[3] = DW'(cur_day);
        now_time[4] = DW'(cur_wday);
    end

    rtc_alarm_regs #(.NF(NF), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .flag_in(alarm_flag), .rdata(reg_rdata),
        .setting(setting), .aie(aie), .clr_req(clr_req)
    );

    rtc_alarm_cmp #(.NF(NF), .DW(DW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .setting(setting), .now_time(now_time),
        .match(match)
    );

    rtc_alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .match(match),
        .clr_req(clr_req), .aie(aie), .flag(alarm_flag), .irq_n(irq_n)
    );

    // An active request always has a flag behind it (R9).
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> alarm_flag);
endmodule

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0;
    logic [5:0] cur_hour = '0, cur_day = '0;
    logic [2:0] cur_wday = '0;
    logic reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic alarm_flag, irq_n;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    rtc_alarm_match u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_sec(cur_sec),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .cur_wday(cur_wday), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // Fixed live time used by the sweeps.
    localparam logic [7:0] TV [5] = '{8'h37, 8'h42, 8'h15, 8'h28, 8'h05};

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            rd(5'h0A + 5'(i), d);
            check("R1 setting reset", d, 8'h80);
        end
        rd(5'h01, d);
        check("R1 ctrl reset", d, 0);
        check("R1 flag reset", alarm_flag, 0);
        check("R1 irq reset", irq_n, 1);

        // R2 register storage, unused addresses
        wr(5'h0B, 8'hA5);
        rd(5'h0B, d);
        check("R2 full byte stored", d, 8'hA5);
        wr(5'h05, 8'hFF);
        rd(5'h05, d);
        check("R2 unused reads zero", d, 0);
        rd(5'h0B, d);
        check("R2 unused write ignored", d, 8'hA5);
        wr(5'h01, 8'hFF);
        rd(5'h01, d);
        check("R2 ctrl bits", d, 8'h02);
        wr(5'h01, 8'h00);

        cur_sec = TV[0][6:0]; cur_min = TV[1][6:0]; cur_hour = TV[2][5:0];
        cur_day = TV[3][5:0]; cur_wday = TV[4][2:0];

        // R5 all excluded: tick with raw values equal below bit 7
        for (int i = 0; i < 5; i++) wr(5'h0A + 5'(i), 8'h80 | TV[i]);
        tick();
        check("R5 all excluded no flag", alarm_flag, 0);

        // R3 sweep over enable masks and mismatch patterns
        for (int m = 0; m < 32; m++) begin
            for (int p = 0; p < 32; p++) begin
                wr(5'h01, 8'h00);
                for (int i = 0; i < 5; i++) begin
                    logic [7:0] v;
                    v = p[i] ? (TV[i] ^ 8'h01) : TV[i];
                    if (!m[i]) v = v | 8'h80;
                    wr(5'h0A + 5'(i), v);
                end
                tick();
                check($sformatf("R3 mask=%0d pat=%0d", m, p), alarm_flag,
                      (m != 0 && (m & p) == 0) ? 1 : 0);
            end
        end

        // R4 upper bits beyond compared width ignored
        wr(5'h01, 8'h00);
        wr(5'h0A, 8'h80); wr(5'h0B, 8'h80); wr(5'h0D, 8'h80);
        wr(5'h0C, 8'h40 | TV[2]);
        wr(5'h0E, 8'h78 | TV[4]);
        tick();
        check("R4 hour/wday wide bits ignored", alarm_flag, 1);
        wr(5'h01, 8'h00);
        wr(5'h0C, 8'h80); wr(5'h0E, 8'h80);
        // R4 seconds sweep: 7-bit compare against every value
        for (int s = 0; s < 128; s++) begin
            wr(5'h01, 8'h00);
            wr(5'h0A, 8'h59);
            cur_sec = 7'(s);
            tick();
            check($sformatf("R4 sec sweep %0d", s), alarm_flag, (s == 8'h59) ? 1 : 0);
        end
        cur_sec = 7'h59;

        // R6 no tick, no set
        wr(5'h01, 8'h00);
        repeat (5) @(negedge clk);
        check("R6 no set without tick", alarm_flag, 0);
        tick();
        check("R6 set after tick", alarm_flag, 1);

        // R8 hold through mismatch ticks
        cur_sec = 7'h00;
        tick(); tick();
        check("R8 flag holds", alarm_flag, 1);
        // R7 write bit4=1 keeps flag; clear
        wr(5'h01, 8'h10);
        check("R7 bit4 one keeps flag", alarm_flag, 1);
        rd(5'h01, d);
        check("R2 flag readable", d, 8'h10);
        wr(5'h01, 8'h00);
        check("R7 clear", alarm_flag, 0);
        wr(5'h01, 8'h10);
        check("R7 bit4 one does not set", alarm_flag, 0);
        // R7 same-cycle clear and set
        cur_sec = 7'h59;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h01; reg_wdata = 8'h00; sec_tick = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; sec_tick = 1'b0;
        check("R7 set wins over clear", alarm_flag, 1);

        // R9 interrupt gating
        check("R9 no irq when disabled", irq_n, 1);
        wr(5'h01, 8'h12);
        check("R9 irq active", irq_n, 0);
        wr(5'h01, 8'h02);
        check("R9 irq released on clear", irq_n, 1);
        tick();
        check("R9 irq on new match", irq_n, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule